// File: doc/BRIEF.md
# Integer Butterfly Multiply-Accumulate Unit

This block carries out one integer butterfly step of the kind found in FFT and DCT inner loops. It takes two data operands a and b, a coefficient c, a second accumulator s and a 4-bit rotate amount. It forms the sum a+b and the difference a-b and multiplies each by the same coefficient. Each product is rotated right by the rotate amount, and the two rotated values are added into two separate accumulators. The first accumulator is operand a itself, so its new value replaces a. The second accumulator is s.

The rotate amount, the record request and the destination index all come from one 32-bit instruction word that the block splits into fields. The source indices are also decoded and brought out without a register, so that surrounding logic can fetch the operands. A match output says whether the word carries the configured primary and extended opcodes. When the record bit is set, the block also returns sign/zero condition flags for the new first accumulator.

Work moves through a fixed two-stage pipeline with a valid/ready handshake. A single stall enable holds both stages together whenever a finished result is waiting and has not yet been taken.

Top module: `bfly_butterfly_mac`

## Requirements
- R1: Bits are numbered with 0 as the MSB. The instruction word splits into: primary opcode in bits 0-5 (insn[31:26]), destination index in 6-10 (insn[25:21]), first source index in 11-15 (insn[20:16]), second source index in 16-20 (insn[15:11]), rotate amount in 21-24 (insn[10:7]), extended opcode in 25-30 (insn[6:1]) and record bit in 31 (insn[0]). dec_rt, dec_ra and dec_rb show the index fields without a register delay. dec_hit is 1 exactly when both opcodes equal the configured values.
- R2: res_a = a + rotr(c*(a+b), sh), computed modulo 2^XLEN.
- R3: res_s = s + rotr(c*(a-b), sh), computed modulo 2^XLEN.
- R4: rotr rotates right by sh positions, with sh from 0 to 15. An sh of 0 leaves the product unchanged.
- R5: Each product keeps only the low XLEN bits of the XLEN x XLEN multiply, with operands taken as two's complement. All additions wrap.
- R6: A result whose record bit is 1 loads flags = {LT, GT, EQ} (bit 2 = LT, bit 1 = GT, bit 0 = EQ). The flags come from a signed comparison of res_a against zero. Exactly one of the three bits is set.
- R7: A result whose record bit is 0 leaves flags unchanged.
- R8: in_ready = out_ready || !out_valid. A word accepted on one clock edge appears on the outputs after the second edge. res_rt and res_rc return that word's destination index and record bit.
- R9: While out_valid is 1 and out_ready is 0, out_valid, res_a and res_s hold steady and no new word is accepted.
- R10: While rst_n is low, out_valid is 0 and flags is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word and operands are present |
| in_ready | output | 1 | Block accepts input this cycle |
| insn | input | 32 | Instruction word |
| opnd_a | input | XLEN | Operand a, also the first accumulator |
| opnd_b | input | XLEN | Operand b |
| coef_c | input | XLEN | Coefficient |
| acc_s | input | XLEN | Second accumulator |
| dec_rt | output | 5 | Destination index, no register delay |
| dec_ra | output | 5 | First source index, no register delay |
| dec_rb | output | 5 | Second source index, no register delay |
| dec_hit | output | 1 | Opcode fields match the configured values |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| res_a | output | XLEN | New first accumulator |
| res_s | output | XLEN | New second accumulator |
| res_rt | output | 5 | Destination index of the result |
| res_rc | output | 1 | Record bit of the result |
| flags | output | 3 | {LT, GT, EQ} of res_a |

## Verification
The decoded index fields and dec_hit are combinational, so they are checked in the same cycle the word is driven. A result is due on the second clock edge after its word is accepted, provided out_ready stays high. The bench checks this directly once after reset: out_valid must be low after the first edge and high after the second. Under random back-pressure the bench instead queues an expected result for each accepted word and compares the front of the queue whenever a result is taken. It checks flags against its own flag model at that same moment, and during stalls it checks that the held outputs have not moved.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;
  localparam int SH_W   = 4;
  localparam int OPC_W  = 6;
  localparam int FLG_W  = 3;
  localparam int FLG_LT = 2;
  localparam int FLG_GT = 1;
  localparam int FLG_EQ = 0;

  typedef struct packed {
    logic [OPC_W-1:0] po;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] ra;
    logic [IDX_W-1:0] rb;
    logic [SH_W-1:0]  sh;
    logic [OPC_W-1:0] xo;
    logic             rc;
  } bfly_insn_t;
endpackage

// File: rtl/bfly_insn_split.sv
module bfly_insn_split
  import bfly_pkg::*;
#(
  parameter logic [OPC_W-1:0] PO_CODE = 6'd22,
  parameter logic [OPC_W-1:0] XO_CODE = 6'd8
) (
  input  logic [INSN_W-1:0] insn,
  output bfly_insn_t        fld,
  output logic              hit
);
  // bit 0 of the word is its MSB
  always_comb begin
    fld.po = insn[31:26];
    fld.rt = insn[25:21];
    fld.ra = insn[20:16];
    fld.rb = insn[15:11];
    fld.sh = insn[10:7];
    fld.xo = insn[6:1];
    fld.rc = insn[0];
    hit    = (fld.po == PO_CODE) && (fld.xo == XO_CODE);
  end
endmodule

// File: rtl/bfly_rotr.sv
module bfly_rotr #(
  parameter int XLEN = 64,
  parameter int SHW  = 4
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] lvl [SHW+1];

  assign lvl[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_lvl
    localparam int D = 1 << k;
    assign lvl[k+1] = amt[k] ? {lvl[k][D-1:0], lvl[k][XLEN-1:D]} : lvl[k];
  end

  assign dout = lvl[SHW];
endmodule

// File: rtl/bfly_mul_stage.sv
module bfly_mul_stage #(
  parameter int XLEN = 64,
  parameter int SHW  = 4,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            in_valid,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] c,
  input  logic [XLEN-1:0] s,
  input  logic [SHW-1:0]  sh,
  input  logic            rc,
  input  logic [IDXW-1:0] rt,
  output logic            s1_valid,
  output logic [XLEN-1:0] s1_p1,
  output logic [XLEN-1:0] s1_p2,
  output logic [XLEN-1:0] s1_a,
  output logic [XLEN-1:0] s1_s,
  output logic [SHW-1:0]  s1_sh,
  output logic            s1_rc,
  output logic [IDXW-1:0] s1_rt
);
  logic [XLEN-1:0] sum_w, diff_w, p1_nxt, p2_nxt;
  logic            valid_nxt, ld;

  always_comb begin
    sum_w     = a + b;
    diff_w    = a - b;
    p1_nxt    = sum_w * c;
    p2_nxt    = diff_w * c;
    valid_nxt = en ? in_valid : s1_valid;
    ld        = en && in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      s1_p1 <= p1_nxt;
      s1_p2 <= p2_nxt;
      s1_a  <= a;
      s1_s  <= s;
      s1_sh <= sh;
      s1_rc <= rc;
      s1_rt <= rt;
    end
  end

  AST_S1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !en |=> s1_valid && $stable(s1_p1) && $stable(s1_p2)); // R9
endmodule

// File: rtl/bfly_rot_acc_stage.sv
module bfly_rot_acc_stage
  import bfly_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SHW  = 4,
  parameter int IDXW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             s1_valid,
  input  logic [XLEN-1:0]  s1_p1,
  input  logic [XLEN-1:0]  s1_p2,
  input  logic [XLEN-1:0]  s1_a,
  input  logic [XLEN-1:0]  s1_s,
  input  logic [SHW-1:0]   s1_sh,
  input  logic             s1_rc,
  input  logic [IDXW-1:0]  s1_rt,
  output logic             out_valid,
  output logic [XLEN-1:0]  res_a,
  output logic [XLEN-1:0]  res_s,
  output logic [IDXW-1:0]  res_rt,
  output logic             res_rc,
  output logic [FLG_W-1:0] flags
);
  logic [XLEN-1:0]  rot1, rot2, a_nxt, s_nxt;
  logic [FLG_W-1:0] flags_nxt;
  logic             valid_nxt, ld, flag_ld;

  bfly_rotr #(.XLEN(XLEN), .SHW(SHW)) u_rot1 (.din(s1_p1), .amt(s1_sh), .dout(rot1));
  bfly_rotr #(.XLEN(XLEN), .SHW(SHW)) u_rot2 (.din(s1_p2), .amt(s1_sh), .dout(rot2));

  always_comb begin
    a_nxt     = s1_a + rot1;
    s_nxt     = s1_s + rot2;
    valid_nxt = en ? s1_valid : out_valid;
    ld        = en && s1_valid;
    flag_ld   = ld && s1_rc;
    flags_nxt = flags;
    if (flag_ld) begin
      flags_nxt         = '0;
      flags_nxt[FLG_LT] = a_nxt[XLEN-1];
      flags_nxt[FLG_EQ] = (a_nxt == '0);
      flags_nxt[FLG_GT] = !a_nxt[XLEN-1] && (a_nxt != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flags     <= '0;
    end else begin
      out_valid <= valid_nxt;
      flags     <= flags_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      res_a  <= a_nxt;
      res_s  <= s_nxt;
      res_rt <= s1_rt;
      res_rc <= s1_rc;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !en |=> out_valid && $stable(res_a) && $stable(res_s)); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && s1_valid && !s1_rc |=> $stable(flags)); // R7
  AST_FLAG_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(en && s1_valid && s1_rc) |-> (flags[FLG_EQ] == (res_a == '0))); // R6
  AST_FLAG_LT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(en && s1_valid && s1_rc) |-> (flags[FLG_LT] == res_a[XLEN-1])); // R6
endmodule

// File: rtl/bfly_butterfly_mac.sv
module bfly_butterfly_mac
  import bfly_pkg::*;
#(
  parameter int               XLEN    = 64,
  parameter logic [OPC_W-1:0] PO_CODE = 6'd22,
  parameter logic [OPC_W-1:0] XO_CODE = 6'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [XLEN-1:0]   coef_c,
  input  logic [XLEN-1:0]   acc_s,
  output logic [IDX_W-1:0]  dec_rt,
  output logic [IDX_W-1:0]  dec_ra,
  output logic [IDX_W-1:0]  dec_rb,
  output logic              dec_hit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   res_a,
  output logic [XLEN-1:0]   res_s,
  output logic [IDX_W-1:0]  res_rt,
  output logic              res_rc,
  output logic [FLG_W-1:0]  flags
);
  logic       rst_meta, rst_sync_n;
  logic       en;
  bfly_insn_t fld;

  logic             s1_valid, s1_rc;
  logic [XLEN-1:0]  s1_p1, s1_p2, s1_a, s1_s;
  logic [SH_W-1:0]  s1_sh;
  logic [IDX_W-1:0] s1_rt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  bfly_insn_split #(.PO_CODE(PO_CODE), .XO_CODE(XO_CODE)) u_split (
    .insn(insn), .fld(fld), .hit(dec_hit)
  );

  always_comb begin
    dec_rt   = fld.rt;
    dec_ra   = fld.ra;
    dec_rb   = fld.rb;
    en       = out_ready || !out_valid;
    in_ready = en;
  end

  bfly_mul_stage #(.XLEN(XLEN), .SHW(SH_W), .IDXW(IDX_W)) u_s1 (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .in_valid(in_valid),
    .a(opnd_a), .b(opnd_b), .c(coef_c), .s(acc_s),
    .sh(fld.sh), .rc(fld.rc), .rt(fld.rt),
    .s1_valid(s1_valid), .s1_p1(s1_p1), .s1_p2(s1_p2), .s1_a(s1_a),
    .s1_s(s1_s), .s1_sh(s1_sh), .s1_rc(s1_rc), .s1_rt(s1_rt)
  );

  bfly_rot_acc_stage #(.XLEN(XLEN), .SHW(SH_W), .IDXW(IDX_W)) u_s2 (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .s1_valid(s1_valid),
    .s1_p1(s1_p1), .s1_p2(s1_p2), .s1_a(s1_a), .s1_s(s1_s),
    .s1_sh(s1_sh), .s1_rc(s1_rc), .s1_rt(s1_rt),
    .out_valid(out_valid), .res_a(res_a), .res_s(res_s),
    .res_rt(res_rt), .res_rc(res_rc), .flags(flags)
  );

  AST_ACCEPT_ADV: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && in_ready |=> s1_valid); // R8
  AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(flags)); // R6
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

// File: tb/tb_bfly_butterfly_mac.sv
module tb_bfly_butterfly_mac;
  localparam int XLEN = 64;
  localparam logic [5:0] PO = 6'd22;
  localparam logic [5:0] XO = 6'd8;

  logic            clk, rst_n, in_valid, in_ready, out_valid, out_ready, dec_hit, res_rc;
  logic [31:0]     insn;
  logic [XLEN-1:0] opnd_a, opnd_b, coef_c, acc_s, res_a, res_s;
  logic [4:0]      dec_rt, dec_ra, dec_rb, res_rt;
  logic [2:0]      flags;

  bfly_butterfly_mac #(.XLEN(XLEN), .PO_CODE(PO), .XO_CODE(XO)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .insn(insn),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .coef_c(coef_c), .acc_s(acc_s),
    .dec_rt(dec_rt), .dec_ra(dec_ra), .dec_rb(dec_rb), .dec_hit(dec_hit),
    .out_valid(out_valid), .out_ready(out_ready), .res_a(res_a), .res_s(res_s),
    .res_rt(res_rt), .res_rc(res_rc), .flags(flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [XLEN-1:0] qa[$], qs[$];
  logic [4:0]      qrt[$];
  bit              qrc[$];
  logic [2:0]      mflags;
  bit              prev_stall;
  logic [XLEN-1:0] prev_a, prev_s;

  task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] m_rotr(input logic [XLEN-1:0] x, input logic [3:0] n);
    logic [XLEN-1:0] r;
    r = x;
    for (int i = 0; i < int'(n); i++) r = {r[0], r[XLEN-1:1]};
    return r;
  endfunction

  function automatic logic [2:0] m_flags(input logic [XLEN-1:0] v);
    if ($signed(v) < 0)  return 3'b100;
    if (v == '0)         return 3'b001;
    return 3'b010;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [5:0] po, input logic [4:0] rt,
      input logic [4:0] ra, input logic [4:0] rb, input logic [3:0] sh,
      input logic [5:0] xo, input bit rc);
    return {po, rt, ra, rb, sh, xo, rc};
  endfunction

  task automatic scoreboard();
    logic [XLEN-1:0] ea, es;
    logic [4:0] ert;
    bit erc;
    // R8 ready rule
    chk(in_ready == (out_ready || !out_valid), "R8 in_ready", in_ready, out_ready || !out_valid);
    // R9 held outputs during stall
    if (prev_stall) begin
      chk(out_valid && res_a == prev_a && res_s == prev_s, "R9 stall hold", res_a, prev_a);
    end
    prev_stall = out_valid && !out_ready;
    prev_a = res_a;
    prev_s = res_s;
    // R1 combinational field split
    if (in_valid) begin
      chk({dec_rt, dec_ra, dec_rb} == {insn[25:21], insn[20:16], insn[15:11]},
          "R1 index fields", {dec_rt, dec_ra, dec_rb}, {insn[25:21], insn[20:16], insn[15:11]});
      chk(dec_hit == (insn[31:26] == PO && insn[6:1] == XO), "R1 opcode hit",
          dec_hit, (insn[31:26] == PO && insn[6:1] == XO));
    end
    if (out_valid && out_ready) begin
      if (qa.size() == 0) begin
        chk(0, "R8 unexpected result", res_a, 0);
      end else begin
        ea = qa.pop_front(); es = qs.pop_front(); ert = qrt.pop_front(); erc = qrc.pop_front();
        chk(res_a == ea, "R2 res_a", res_a, ea);
        chk(res_s == es, "R3 res_s", res_s, es);
        chk(res_rt == ert && res_rc == erc, "R8 res_rt/res_rc", {res_rt, res_rc}, {ert, erc});
        if (erc) mflags = m_flags(ea);
        chk(flags == mflags, erc ? "R6 flags" : "R7 flags kept", flags, mflags);
      end
    end
    if (in_valid && in_ready) begin
      qa.push_back(opnd_a + m_rotr((opnd_a + opnd_b) * coef_c, insn[10:7]));
      qs.push_back(acc_s + m_rotr((opnd_a - opnd_b) * coef_c, insn[10:7]));
      qrt.push_back(insn[25:21]);
      qrc.push_back(insn[0]);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input logic [XLEN-1:0] a,
      input logic [XLEN-1:0] b, input logic [XLEN-1:0] c, input logic [XLEN-1:0] s,
      input bit ordy);
    @(negedge clk);
    in_valid = v; insn = w; opnd_a = a; opnd_b = b; coef_c = c; acc_s = s;
    out_ready = ordy;
    #1;
    scoreboard();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic logic [XLEN-1:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'h1bf5));
    mflags = 3'b000; prev_stall = 0;
    rst_n = 1'b0; in_valid = 0; out_ready = 1; insn = '0;
    opnd_a = '0; opnd_b = '0; coef_c = '0; acc_s = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10 out_valid in reset", out_valid, 0);
    chk(flags == 3'b000, "R10 flags in reset", flags, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 latency: accept on edge 1, visible after edge 2
    step(1, mk_insn(PO, 5'd3, 5'd4, 5'd5, 4'd0, XO, 1), 64'd5, 64'd3, 64'd2, 64'd100, 1);
    step(0, '0, '0, '0, '0, '0, 1);
    chk(out_valid == 0, "R8 not yet valid after one edge", out_valid, 0);
    step(0, '0, '0, '0, '0, '0, 1);
    chk(out_valid == 1, "R8 valid after two edges", out_valid, 1);

    // R4 sh=0 and sh=15, R5 negative wrap, R6 zero result -> EQ, R7 hold
    step(1, mk_insn(PO, 5'd1, 5'd2, 5'd3, 4'd15, XO, 1), 64'd1, 64'd0, 64'd1, 64'd7, 1);
    step(1, mk_insn(PO, 5'd2, 5'd2, 5'd3, 4'd4, XO, 1), 64'd0, 64'd0, 64'd9, 64'd0, 1);
    step(1, mk_insn(PO, 5'd6, 5'd2, 5'd3, 4'd1, XO, 0), 64'd9, 64'd9, 64'd3, 64'd1, 1);
    step(1, mk_insn(PO, 5'd7, 5'd2, 5'd3, 4'd0, XO, 1), -64'sd10, 64'd3,
         64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1);
    step(1, mk_insn(6'd1, 5'd8, 5'd0, 5'd1, 4'd9, 6'd1, 0), 64'h8000_0000_0000_0000,
         64'h8000_0000_0000_0000, 64'd3, -64'sd1, 1);
    // R9 stall with pending work
    step(0, '0, '0, '0, '0, '0, 0);
    step(1, mk_insn(PO, 5'd9, 5'd1, 5'd1, 4'd2, XO, 1), 64'd11, 64'd22, 64'd5, 64'd1, 0);
    step(1, mk_insn(PO, 5'd9, 5'd1, 5'd1, 4'd2, XO, 1), 64'd11, 64'd22, 64'd5, 64'd1, 0);
    for (int i = 0; i < 6; i++) step(0, '0, '0, '0, '0, '0, 1);

    // random stream with random back-pressure
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] po, xo;
      po = ($urandom_range(0, 1) == 1) ? PO : 6'($urandom());
      xo = ($urandom_range(0, 1) == 1) ? XO : 6'($urandom());
      step($urandom_range(0, 3) != 0,
           mk_insn(po, 5'($urandom()), 5'($urandom()), 5'($urandom()), 4'($urandom()),
                   xo, 1'($urandom())),
           ($urandom_range(0, 7) == 0) ? 64'd0 : r64(), r64(),
           ($urandom_range(0, 7) == 0) ? 64'd1 : r64(), r64(),
           $urandom_range(0, 3) != 0);
    end
    for (int i = 0; i < 10; i++) step(0, '0, '0, '0, '0, '0, 1);
    chk(qa.size() == 0, "R8 all results delivered", qa.size(), 0);
    finish_run();
  end
endmodule